// File: doc/BRIEF.md
# Fractional Clock Divider Generator

This block produces a divided clock from one of several source tick lines. The division ratio is an integer plus an 8-bit fraction. An accumulator spreads the fractional part over successive output periods, so the average period is exact while each single period stays a whole number of source cycles. Software writes a control word and a divisor word through a small write/read port. Both words can be rewritten while the generator runs. A new divisor always takes effect at an output period boundary.

The control word carries several fields. A run bit starts and stops the output without cutting a pulse short, and a kill bit silences it at once. A half-duty bit gives odd period lengths a 50% duty cycle. A 2-bit phase field delays the start by 0 to 3 source cycles, and a nudge bit slips the output by one source cycle each time it toggles. The whole block works in the single `clk` domain. A source line advances the divider only in cycles where its tick is high. The output is given as a pair of half-cycle levels, so that widths can be counted in half cycles.

Top module: `frac_clkgen`

## Requirements
- R1: After reset the control word reads 0, the divisor word reads 0x00000100, `div_out` is 2'b00 and `period_start` is 0.
- R2: The divisor word holds the integer part in bits [31:8] and the fraction in bits [7:0]. An integer part of 0 gives a period of 65536 source cycles. An integer part of 1 with fraction 0 and half-duty off holds `div_out` at 2'b11, with `period_start` high every cycle.
- R3: With half-duty off, a period of P cycles drives both bits of `div_out` high for the first ceil(P/2) cycles and low for the rest. Bit 0 is the first half of a cycle and bit 1 is the second half.
- R4: With half-duty on (control bit 2) and an odd period length P, the output falls in the middle of a cycle and stays high for exactly P half cycles. With P=1 this gives 2'b01 every cycle.
- R5: Each period adds the fraction to an 8-bit accumulator, and a carry lengthens that period by one cycle. Fraction 0x40 with integer 4 gives periods of 4 or 5 cycles, summing to 34 over any 8 periods.
- R6: A divisor written in the middle of a period leaves that period's length unchanged. The new length applies from the next period.
- R7: Clearing the run bit (control bit 0) lets the current period finish. No `period_start` follows and the output stays low.
- R8: Setting the kill bit (control bit 1) forces `div_out` to 2'b00 from the next cycle on and stops the generator without waiting for the period to end. Clearing it with run set restarts the generator.
- R9: The phase field (control bits [4:3]) delays the start by k cycles. After the edge that writes run, the first `period_start` comes 1+k cycles later.
- R10: Each toggle of the nudge bit (control bit 5) lengthens the period in progress by one cycle, once per toggle.
- R11: The source field (control bits [7:6]) selects which `src_tick` line advances the divider. Lines that are not selected have no effect.
- R12: The read port returns the control word at address 0 and the divisor word at address 1, as they were last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 4 | Per-source advance ticks |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 divisor |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 divisor |
| rd_data | output | 32 | Read data |
| div_out | output | 2 | Divided clock level: bit 0 first half cycle, bit 1 second half |
| period_start | output | 1 | High in the first counted cycle of each output period |

## Verification
The divider is driven with integer ratios of 1, 4, 5 and 65536, and the high and low widths are counted in half cycles. These runs separate the rounding of even periods from that of odd periods, and they show whether the half-duty bit actually moves the falling edge. A ratio of 4 with fraction 0x40 is measured over eight periods, which shows whether the carry lengthens exactly one period in four. Divisor rewrites, run clears, kills, nudges and phase values are each applied at a known point in a period, and the distance between `period_start` pulses shows whether the change lands at the boundary, mid-period or after the promised delay. An alternating tick on a selected source, with the unselected source held low, separates correct source selection from a divider that counts on the wrong line.

// File: rtl/frac_clkgen_pkg.sv
package frac_clkgen_pkg;

    localparam int DATA_W   = 32;
    localparam int INT_W    = 24;
    localparam int FRAC_W   = 8;
    localparam int PHASE_W  = 2;
    localparam int SRC_W    = 2;
    localparam int LEN_W    = INT_W + 1;
    localparam int ZERO_DIV = 65536;

    // control word, LSB first: run, kill, half_duty, phase, nudge, src
    typedef struct packed {
        logic [SRC_W-1:0]   src;
        logic               nudge;
        logic [PHASE_W-1:0] phase;
        logic               half_duty;
        logic               kill;
        logic               run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } divw_t;

    function automatic logic [LEN_W-1:0] base_len(input logic [INT_W-1:0] ip);
        return (ip == '0) ? LEN_W'(ZERO_DIV) : {1'b0, ip};
    endfunction

endpackage

// File: rtl/fcg_regs.sv
module fcg_regs
    import frac_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctrl_t             ctrl,
    output divw_t             divw
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            divw <= '{ipart: INT_W'(1), fpart: '0};
        end else if (wr_en) begin
            if (wr_addr) divw <= divw_t'(wr_data);
            else         ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign rd_data = rd_addr ? DATA_W'(divw) : {{(DATA_W-CTRL_W){1'b0}}, ctrl};
endmodule

// File: rtl/fcg_phase_delay.sv
module fcg_phase_delay #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en_in,
    input  logic [PW-1:0] phase,
    output logic          en_out
);
    localparam int DEPTH = (1 << PW) - 1;

    logic [DEPTH-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            taps <= '0;
        end else begin
            taps[0] <= en_in;
            for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
    end

    assign en_out = (phase == '0) ? en_in : taps[phase - PW'(1)];
endmodule

// File: rtl/fcg_period_engine.sv
module fcg_period_engine
    import frac_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en,
    input  logic              kill,
    input  logic              half_duty,
    input  logic              nudge_lvl,
    input  divw_t             divw,
    output logic              running,
    output logic              period_start,
    output logic              period_end,
    output logic              load,
    output logic [LEN_W-1:0]  per_len,
    output logic [1:0]        div_out
);
    logic [LEN_W-1:0]  cnt, hi_len, new_len;
    logic [FRAC_W-1:0] acc, acc_nx;
    logic              carry, half_q, nudge_prev, nudge_pend;
    logic              nudge_edge, hold, adv, start, active;

    assign nudge_edge   = nudge_lvl ^ nudge_prev;
    assign hold         = running && (nudge_edge || nudge_pend);
    assign adv          = running && tick && !hold;
    assign period_end   = adv && (cnt == per_len - LEN_W'(1));
    assign period_start = adv && (cnt == '0);
    assign start        = !running && en && tick && !kill;
    assign load         = start || (period_end && en);

    assign {carry, acc_nx} = {1'b0, acc} + {1'b0, divw.fpart};
    assign new_len         = base_len(divw.ipart) + LEN_W'(carry);

    always_ff @(posedge clk) begin
        if (rst) begin
            running    <= 1'b0;
            cnt        <= '0;
            per_len    <= '0;
            hi_len     <= '0;
            half_q     <= 1'b0;
            acc        <= '0;
            nudge_prev <= 1'b0;
            nudge_pend <= 1'b0;
        end else begin
            nudge_prev <= nudge_lvl;
            if (kill)                  nudge_pend <= 1'b0;
            else if (hold && tick)     nudge_pend <= 1'b0;
            else if (nudge_edge)       nudge_pend <= 1'b1;

            if (kill) begin
                running <= 1'b0;
            end else if (load) begin
                running <= 1'b1;
                cnt     <= '0;
                per_len <= new_len;
                hi_len  <= new_len - (new_len >> 1);
                half_q  <= half_duty & new_len[0];
                acc     <= acc_nx;
            end else if (period_end) begin
                running <= 1'b0;
            end else if (adv) begin
                cnt <= cnt + LEN_W'(1);
            end
        end
    end

    // bit 0: first half of the cycle, bit 1: second half
    assign active     = running && !kill;
    assign div_out[0] = active && (cnt < hi_len);
    assign div_out[1] = active && (half_q ? (cnt + LEN_W'(1) < hi_len) : (cnt < hi_len));
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
    import frac_clkgen_pkg::*;
#(
    parameter int NSRC = 1 << SRC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        div_out,
    output logic              period_start
);
    ctrl_t            ctrl;
    divw_t            divw;
    logic             en_req, en_eff, tick, kill_q;
    logic             running, period_end, load;
    logic [LEN_W-1:0] per_len;

    fcg_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl(ctrl), .divw(divw)
    );

    assign kill_q = ctrl.kill;
    assign en_req = ctrl.run && !ctrl.kill;
    assign tick   = src_tick[ctrl.src];

    fcg_phase_delay #(.PW(PHASE_W)) u_phase (
        .clk(clk), .rst(rst), .clr(kill_q), .en_in(en_req),
        .phase(ctrl.phase), .en_out(en_eff)
    );

    fcg_period_engine u_engine (
        .clk(clk), .rst(rst), .tick(tick), .en(en_eff), .kill(kill_q),
        .half_duty(ctrl.half_duty), .nudge_lvl(ctrl.nudge), .divw(divw),
        .running(running), .period_start(period_start), .period_end(period_end),
        .load(load), .per_len(per_len), .div_out(div_out)
    );
endmodule

// File: rtl/fcg_chk.sv
module fcg_chk #(
    parameter int LEN_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             kill_q,
    input logic             period_end,
    input logic             load,
    input logic [LEN_W-1:0] per_len,
    input logic [1:0]       div_out
);
    // R8
    kill_stops_chk: assert property (@(posedge clk) disable iff (rst)
        kill_q |=> !running);

    // R7
    clean_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(running) && !$past(kill_q)) |-> $past(period_end));

    // R4
    half_order_chk: assert property (@(posedge clk) disable iff (rst)
        div_out[1] |-> div_out[0]);

    // R6
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && $past(running) && !$past(load)) |-> $stable(per_len));

    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> (div_out == 2'b00));

    // R2
    nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (per_len != '0));
endmodule

bind frac_clkgen fcg_chk #(.LEN_W(frac_clkgen_pkg::LEN_W)) u_chk (
    .clk(clk), .rst(rst), .running(running), .kill_q(kill_q),
    .period_end(period_end), .load(load), .per_len(per_len), .div_out(div_out)
);

// File: tb/test_frac_clkgen.sv
module test_frac_clkgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  div_out;
    logic        period_start;
    logic        alt = 1'b0;
    logic [3:0]  src_tick;
    int          total = 0, bad = 0;
    longint      cyc = 0;
    longint      ncyc = 0;
    logic [1:0]  hb;
    int          hidx = 2;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) ncyc <= ncyc + 1;

    assign src_tick = {2'b00, alt ? ncyc[0] : 1'b1, alt ? 1'b0 : 1'b1};

    frac_clkgen i_frac_clkgen (
        .clk(clk), .rst(rst), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .div_out(div_out), .period_start(period_start)
    );

    function automatic [31:0] cw(bit run, bit kill, bit half, bit [1:0] ph, bit nud, bit [1:0] src);
        return {24'b0, src, nud, ph, half, kill, run};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_gen();
        wr(1'b0, cw(0, 1, 0, 0, 0, 0));
        wr(1'b0, 32'h0);
    endtask

    task automatic wait_ps(output longint t);
        do @(negedge clk); while (!period_start);
        t = cyc;
    endtask

    task automatic get_half(output logic h);
        if (hidx == 2) begin
            @(negedge clk);
            hb = div_out;
            hidx = 0;
        end
        h = hb[hidx];
        hidx++;
    endtask

    task automatic meas(output int hi, output int lo);
        logic   h;
        longint t;
        wait_ps(t);
        hb = div_out; hidx = 0;
        hi = 0; lo = 0;
        get_half(h);
        while (h && hi < 1000)  begin hi++; get_half(h); end
        while (!h && lo < 1000) begin lo++; get_half(h); end
    endtask

    task automatic t_reset();
        rd_addr = 1'b0; #1;
        chk(rd_data == 32'h0, "R1 ctrl reset", rd_data, 0);
        rd_addr = 1'b1; #1;
        chk(rd_data == 32'h100, "R1 div reset", rd_data, 32'h100);
        chk(div_out == 2'b00 && !period_start, "R1 outputs idle", div_out, 0);
    endtask

    task automatic t_div1();
        int errs = 0;
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (div_out != 2'b11 || !period_start) errs++;
            @(negedge clk);
        end
        chk(errs == 0, "R2 divide by one", errs, 0);
        wr(1'b0, cw(1, 0, 1, 0, 0, 0));
        @(negedge clk);
        chk(div_out == 2'b01, "R4 half duty at ratio one", div_out, 1);
        stop_gen();
    endtask

    task automatic t_widths();
        int hi, lo;
        wr(1'b1, 32'h400);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        meas(hi, lo);
        chk(hi == 4 && lo == 4, "R3 even ratio high halves", hi, 4);
        stop_gen();
        wr(1'b1, 32'h500);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        meas(hi, lo);
        chk(hi == 6, "R3 odd ratio high halves", hi, 6);
        chk(lo == 4, "R3 odd ratio low halves", lo, 4);
        wr(1'b0, cw(1, 0, 1, 0, 0, 0));
        meas(hi, lo);
        chk(hi == 5 && lo == 5, "R4 odd ratio half duty", hi * 10 + lo, 55);
        stop_gen();
    endtask

    task automatic t_frac();
        longint t0, t1;
        longint sum = 0;
        int     odd = 0;
        wr(1'b1, 32'h440);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t0);
        for (int i = 0; i < 8; i++) begin
            wait_ps(t1);
            if (t1 - t0 != 4 && t1 - t0 != 5) odd++;
            sum += t1 - t0;
            t0 = t1;
        end
        chk(sum == 34, "R5 eight period sum", sum, 34);
        chk(odd == 0, "R5 period lengths 4 or 5", odd, 0);
        stop_gen();
    endtask

    task automatic t_onfly();
        longint t0, t1, t2;
        wr(1'b1, 32'h400);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t0);
        wr(1'b1, 32'h600);
        wait_ps(t1);
        wait_ps(t2);
        chk(t1 - t0 == 4, "R6 current period kept", t1 - t0, 4);
        chk(t2 - t1 == 6, "R6 new period applied", t2 - t1, 6);
        rd_addr = 1'b1; #1;
        chk(rd_data == 32'h600, "R12 divisor readback", rd_data, 32'h600);
    endtask

    task automatic t_clean_stop();
        longint t0;
        int highs = 0, ps = 0;
        wait_ps(t0);
        wr(1'b0, cw(0, 0, 0, 0, 0, 0));
        for (int i = 0; i < 20; i++) begin
            if (div_out[0]) highs++;
            if (period_start) ps++;
            @(negedge clk);
        end
        chk(highs == 2, "R7 pulse finished", highs, 2);
        chk(ps == 0, "R7 no new period", ps, 0);
    endtask

    task automatic t_kill();
        longint t0;
        int errs = 0, n = 0;
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t0);
        wr(1'b0, cw(1, 1, 0, 0, 0, 0));
        chk(div_out == 2'b00, "R8 immediate silence", div_out, 0);
        for (int i = 0; i < 20; i++) begin
            if (div_out != 2'b00 || period_start) errs++;
            @(negedge clk);
        end
        chk(errs == 0, "R8 stays silent", errs, 0);
        rd_addr = 1'b0; #1;
        chk(rd_data == 32'h3, "R12 control readback", rd_data, 3);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        while (!period_start && n < 10) begin @(negedge clk); n++; end
        chk(n == 1, "R8 restart after kill", n, 1);
        stop_gen();
    endtask

    task automatic t_phase();
        wr(1'b1, 32'h200);
        for (int k = 0; k < 4; k++) begin
            int n = 0;
            stop_gen();
            wr(1'b0, cw(1, 0, 0, 2'(k), 0, 0));
            while (!period_start && n < 20) begin @(negedge clk); n++; end
            chk(n == 1 + k, "R9 phase delay", n, 1 + k);
        end
        stop_gen();
    endtask

    task automatic t_nudge();
        longint t0, t1, t2, t3, t4;
        wr(1'b1, 32'h400);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t0);
        wr(1'b0, cw(1, 0, 0, 0, 1, 0));
        wait_ps(t1);
        wait_ps(t2);
        chk(t1 - t0 == 5, "R10 rising nudge stretch", t1 - t0, 5);
        chk(t2 - t1 == 4, "R10 single stretch", t2 - t1, 4);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t3);
        wait_ps(t4);
        chk(t3 - t2 == 5, "R10 falling nudge stretch", t3 - t2, 5);
        chk(t4 - t3 == 4, "R10 back to ratio", t4 - t3, 4);
        stop_gen();
    endtask

    task automatic t_src();
        longint t0, t1;
        alt = 1'b1;
        wr(1'b1, 32'h300);
        wr(1'b0, cw(1, 0, 0, 0, 0, 1));
        wait_ps(t0);
        wait_ps(t1);
        chk(t1 - t0 == 6, "R11 selected half-rate source", t1 - t0, 6);
        stop_gen();
        alt = 1'b0;
    endtask

    task automatic t_big();
        longint t0, t1;
        wr(1'b1, 32'h0);
        wr(1'b0, cw(1, 0, 0, 0, 0, 0));
        wait_ps(t0);
        wait_ps(t1);
        chk(t1 - t0 == 65536, "R2 integer zero", t1 - t0, 65536);
        stop_gen();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_div1();
        t_widths();
        t_frac();
        t_onfly();
        t_clean_stop();
        t_kill();
        t_phase();
        t_nudge();
        t_src();
        t_big();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule